// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of a packet DMA engine. A one-cycle poll pulse starts a pass over a ring of 32-byte descriptors held in system memory. For each descriptor the block reads the first four words through a simple request/acknowledge memory master port. It then fetches the segment's bytes from the buffer address and presents them one byte per beat on a valid/ready frame stream with start and end markers. Finally it writes word 0 back with the ownership flag cleared and reports the next ring pointer to the register bank.

A pass ends at the first descriptor whose ownership flag is clear. A frame may span several descriptors and closes on the descriptor that carries the last-segment flag. That descriptor also produces the transmit-done and normal-summary status-set pulses. The current-pointer and base registers live outside the block. The block only reads them, and it proposes a new current pointer with a one-cycle write strobe.

Frame stream rules: `fd_valid` is raised only by the block. Once raised, `fd_data`, `fd_sof` and `fd_eof` hold until a cycle in which `fd_ready` is high. Only that cycle transfers the byte. The sink may hold `fd_ready` low for any number of cycles, and the engine then waits without fetching.

Top module: `txr_desc_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req`, `fd_valid`, `cur_ptr_we`, `st_txint_set`, `st_nsum_set` and `len_err` are all low.
- R2: A poll starts a pass at `cur_ptr`, reading words 0..3 at byte offsets 0, 4, 8, 12. If word 0 has bit 31 (owned) clear, the pass stops with no further memory access and no stream beat.
- R3: Word 1 carries the buffer-1 size in bits 15:0 and the buffer-2 size in bits 31:16. The segment length is size1[11:0] + size2[11:0] bytes, all fetched from the word-aligned buffer-1 address in word 2. Bytes go out in increasing address order, with byte 0 of a word in bits 7:0. No memory request is made while a beat is offered.
- R4: Once `fd_valid` is high with `fd_ready` low, the next cycle still shows `fd_valid` high with unchanged data and markers.
- R5: `fd_sof` marks the first byte of a frame. `fd_eof` marks the last byte of a descriptor whose word 0 bit 29 (last segment) is set. Descriptors without bit 29 continue the same frame. A zero-length descriptor emits no beat.
- R6: Each processed descriptor with bit 29 set gives exactly one one-cycle pulse on `st_txint_set` and `st_nsum_set` together. This includes zero-length descriptors.
- R7: After its data, each processed descriptor's word 0 is written back to `cur_ptr` with bit 31 cleared and all other bits unchanged.
- R8: After the write-back, `cur_ptr_we` pulses for one cycle. `cur_ptr_nxt` equals `tx_base` when word 0 bit 21 (end of ring) is set, and `cur_ptr` + 32 otherwise.
- R9: `len_err` pulses once for a descriptor whose size1[11:0] exceeds 2048 or whose size2[11:0] is nonzero, and the descriptor is still processed normally. A size1 of exactly 2048 is not an error.
- R10: Any number of polls arriving during a pass cause exactly one further pass after it ends.
- R11: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. Read data is taken from `mem_rdata` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_req | input | 1 | One-cycle poll-demand pulse |
| tx_base | input | AW | Ring base address from the register bank |
| cur_ptr | input | AW | Current descriptor address from the register bank |
| cur_ptr_nxt | output | AW | Proposed next descriptor address |
| cur_ptr_we | output | 1 | Strobe to load `cur_ptr_nxt` into the register bank |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| fd_valid | output | 1 | Frame byte offered |
| fd_ready | input | 1 | Sink accepts the byte |
| fd_data | output | 8 | Frame byte |
| fd_sof | output | 1 | First byte of a frame |
| fd_eof | output | 1 | Last byte of a frame |
| st_txint_set | output | 1 | Set pulse for the transmit-done status bit |
| st_nsum_set | output | 1 | Set pulse for the normal-summary status bit |
| len_err | output | 1 | Segment length error pulse |

## Verification
The properties assume that the memory responder raises `mem_ack` for a single cycle, and only while a request is pending. They also assume that `cur_ptr` changes only when the register bank applies `cur_ptr_nxt` on `cur_ptr_we`, and that `tx_base` holds still during a pass. The bench keeps to this in three ways. Its responder acknowledges each request once after a pseudo-random wait. Its register-bank model loads the pointer from the strobe alone, except for ring setup done while the engine is quiet. All buffer addresses it writes are word aligned.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_CHECK, S_FETCH, S_EMIT, S_WB, S_STEP
  } txr_state_e;

  // control/status word bit positions that software and hardware share
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 29;
  localparam int EOR_BIT  = 21;
  // second size field starts here in word 1
  localparam int SIZE2_LSB = 16;
endpackage

// File: rtl/txr_poll_latch.sv
`timescale 1ns/1ps
module txr_poll_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic poll,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= poll | (pend & ~take);
  end
endmodule

// File: rtl/txr_seg_check.sv
`timescale 1ns/1ps
module txr_seg_check #(
  parameter int LEN_W  = 12,
  parameter int MAX_B1 = 2048
) (
  input  logic [LEN_W-1:0] size1,
  input  logic [LEN_W-1:0] size2,
  output logic [LEN_W:0]   seg_len,
  output logic             bad
);
  localparam logic [LEN_W:0] LIMIT = (LEN_W+1)'(MAX_B1);

  always_comb begin
    seg_len = {1'b0, size1} + {1'b0, size2};
    bad     = ({1'b0, size1} > LIMIT) || (size2 != '0);
  end
endmodule

// File: rtl/txr_ring_step.sv
`timescale 1ns/1ps
module txr_ring_step #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic          wrap,
  output logic [AW-1:0] nxt
);
  always_comb nxt = wrap ? base : cur + AW'(DESC_BYTES);
endmodule

// File: rtl/txr_desc_walker.sv
`timescale 1ns/1ps
module txr_desc_walker #(
  parameter int AW         = 32,
  parameter int LEN_W      = 12,
  parameter int MAX_B1     = 2048,
  parameter int DESC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_req,
  input  logic [AW-1:0] tx_base,
  input  logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] cur_ptr_nxt,
  output logic          cur_ptr_we,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          fd_valid,
  input  logic          fd_ready,
  output logic [7:0]    fd_data,
  output logic          fd_sof,
  output logic          fd_eof,
  output logic          st_txint_set,
  output logic          st_nsum_set,
  output logic          len_err
);
  import txr_pkg::*;

  localparam int SEG_W  = LEN_W + 1;
  localparam int WOFF_W = SEG_W - 2;

  txr_state_e        state;
  logic [1:0]        idx_q;
  logic [31:0]       w0_q;
  logic [LEN_W-1:0]  sz1_q, sz2_q;
  logic [AW-1:0]     buf_q;
  logic [31:0]       word_q;
  logic [SEG_W-1:0]  rem_q;
  logic [WOFF_W-1:0] woff_q;
  logic [1:0]        bidx_q;
  logic              first_q;
  logic              err_q;

  logic              pend, take, bad;
  logic [SEG_W-1:0]  seg_len;

  assign take = (state == S_IDLE) && pend;

  txr_poll_latch u_poll (
    .clk(clk), .rst_n(rst_n), .poll(poll_req), .take(take), .pend(pend)
  );

  txr_seg_check #(.LEN_W(LEN_W), .MAX_B1(MAX_B1)) u_seg (
    .size1(sz1_q), .size2(sz2_q), .seg_len(seg_len), .bad(bad)
  );

  txr_ring_step #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_step (
    .cur(cur_ptr), .base(tx_base), .wrap(w0_q[EOR_BIT]), .nxt(cur_ptr_nxt)
  );

  // memory master and stream outputs
  always_comb begin
    mem_req   = (state == S_DESC) || (state == S_FETCH) || (state == S_WB);
    mem_we    = (state == S_WB);
    mem_wdata = w0_q & ~(32'h1 << OWN_BIT);
    case (state)
      S_DESC:  mem_addr = cur_ptr + AW'({idx_q, 2'b00});
      S_FETCH: mem_addr = buf_q + AW'({woff_q, 2'b00});
      default: mem_addr = cur_ptr;
    endcase
    fd_valid     = (state == S_EMIT);
    fd_data      = word_q[{bidx_q, 3'b000} +: 8];
    fd_sof       = first_q;
    fd_eof       = w0_q[LAST_BIT] && (rem_q == SEG_W'(1));
    cur_ptr_we   = (state == S_STEP);
    st_txint_set = (state == S_STEP) && w0_q[LAST_BIT];
    st_nsum_set  = (state == S_STEP) && w0_q[LAST_BIT];
    len_err      = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx_q   <= '0;
      w0_q    <= '0;
      sz1_q   <= '0;
      sz2_q   <= '0;
      buf_q   <= '0;
      word_q  <= '0;
      rem_q   <= '0;
      woff_q  <= '0;
      bidx_q  <= '0;
      first_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (pend) begin
            state <= S_DESC;
            idx_q <= '0;
          end
        end
        S_DESC: begin
          if (mem_ack) begin
            idx_q <= idx_q + 2'd1;
            case (idx_q)
              2'd0: begin
                w0_q <= mem_rdata;
                if (!mem_rdata[OWN_BIT]) state <= S_IDLE;
              end
              2'd1: begin
                sz1_q <= mem_rdata[LEN_W-1:0];
                sz2_q <= mem_rdata[SIZE2_LSB +: LEN_W];
              end
              2'd2: buf_q <= mem_rdata[AW-1:0];
              default: state <= S_CHECK;
            endcase
          end
        end
        S_CHECK: begin
          rem_q  <= seg_len;
          woff_q <= '0;
          bidx_q <= '0;
          err_q  <= bad;
          state  <= (seg_len == '0) ? S_WB : S_FETCH;
        end
        S_FETCH: begin
          if (mem_ack) begin
            word_q <= mem_rdata;
            state  <= S_EMIT;
          end
        end
        S_EMIT: begin
          if (fd_ready) begin
            first_q <= 1'b0;
            rem_q   <= rem_q - SEG_W'(1);
            bidx_q  <= bidx_q + 2'd1;
            if (rem_q == SEG_W'(1)) begin
              state <= S_WB;
            end else if (bidx_q == 2'd3) begin
              woff_q <= woff_q + WOFF_W'(1);
              state  <= S_FETCH;
            end
          end
        end
        S_WB: begin
          if (mem_ack) state <= S_STEP;
        end
        S_STEP: begin
          if (w0_q[LAST_BIT]) first_q <= 1'b1;
          idx_q <= '0;
          state <= S_DESC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_walk_chk.sv
`timescale 1ns/1ps
module txr_walk_chk #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] tx_base,
  input logic [AW-1:0] cur_ptr,
  input logic [AW-1:0] cur_ptr_nxt,
  input logic          cur_ptr_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          fd_valid,
  input logic          fd_ready,
  input logic [7:0]    fd_data,
  input logic          fd_sof,
  input logic          fd_eof,
  input logic          st_txint_set,
  input logic          st_nsum_set,
  input logic          len_err
);
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fd_valid && !fd_ready |=> fd_valid && $stable(fd_data) && $stable(fd_sof) && $stable(fd_eof)); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31] && (mem_addr == cur_ptr)); // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ptr_we |-> (cur_ptr_nxt == tx_base) || (cur_ptr_nxt == cur_ptr + AW'(DESC_BYTES))); // R8
  AST_NO_FETCH_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fd_valid |-> !mem_req); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    st_txint_set |=> !st_txint_set && !st_nsum_set); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !len_err); // R9
endmodule

bind txr_desc_walker txr_walk_chk #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_base(tx_base), .cur_ptr(cur_ptr),
  .cur_ptr_nxt(cur_ptr_nxt), .cur_ptr_we(cur_ptr_we), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .fd_valid(fd_valid), .fd_ready(fd_ready), .fd_data(fd_data), .fd_sof(fd_sof),
  .fd_eof(fd_eof), .st_txint_set(st_txint_set), .st_nsum_set(st_nsum_set),
  .len_err(len_err)
);

// File: tb/sim_txr_desc_walker.sv
`timescale 1ns/1ps
module sim_txr_desc_walker;
  localparam int MW = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_req = 1'b0;
  logic [31:0] tx_base = '0;
  logic [31:0] cur_ptr;
  logic [31:0] cur_ptr_nxt;
  logic        cur_ptr_we;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        fd_valid, fd_ready, fd_sof, fd_eof;
  logic [7:0]  fd_data;
  logic        st_txint_set, st_nsum_set, len_err;

  always #4 clk = ~clk;

  txr_desc_walker u0 (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .tx_base(tx_base),
    .cur_ptr(cur_ptr), .cur_ptr_nxt(cur_ptr_nxt), .cur_ptr_we(cur_ptr_we),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fd_valid(fd_valid), .fd_ready(fd_ready),
    .fd_data(fd_data), .fd_sof(fd_sof), .fd_eof(fd_eof), .st_txint_set(st_txint_set),
    .st_nsum_set(st_nsum_set), .len_err(len_err)
  );

  int n_run = 0, n_fail = 0;
  function automatic void chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // memory, shadow for the reference walk, register bank
  logic [31:0] mem [0:MW-1];
  logic [31:0] sh  [0:MW-1];
  logic        ld_stb = 1'b0;
  logic [31:0] ld_val = '0;
  logic        stall_en = 1'b0, rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [1:0]  wcnt;
  logic        rdy_q;

  assign fd_ready = rdy_q;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy_q <= rdy_rand ? (lfsr[3] | lfsr[7]) : 1'b1;
    if (ld_stb) cur_ptr <= ld_val;
    else if (cur_ptr_we) cur_ptr <= cur_ptr_nxt;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == 2'd0) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[12:2]];
        wcnt <= stall_en ? lfsr[1:0] : 2'd0;
      end else begin
        wcnt <= wcnt - 2'd1;
      end
    end
  end

  // reference expectations
  logic [9:0]  byte_q [$];
  logic [31:0] ptr_q  [$];
  logic [31:0] m_cur = '0;
  bit          m_first = 1'b1;
  int          exp_ti, exp_err;
  int          ti_cnt = 0, err_cnt = 0, watch_cnt = 0, quiet = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFF;
  logic        pv = 1'b0, pr = 1'b0;
  logic [9:0]  pd = '0;

  // compared every clock, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(fd_valid && {fd_sof, fd_eof, fd_data} == pd, "R4 beat held", {fd_valid, fd_sof, fd_eof, fd_data}, {1'b1, pd});
      pv = fd_valid; pr = fd_ready; pd = {fd_sof, fd_eof, fd_data};
      if (fd_valid && fd_ready) begin
        if (byte_q.size() == 0) chk(1'b0, "R3 unexpected beat", fd_data, 0);
        else begin
          logic [9:0] e;
          e = byte_q.pop_front();
          chk(fd_data == e[7:0], "R3 byte", fd_data, e[7:0]);
          chk({fd_sof, fd_eof} == e[9:8], "R5 markers", {fd_sof, fd_eof}, e[9:8]);
        end
      end
      if (cur_ptr_we) begin
        if (ptr_q.size() == 0) chk(1'b0, "R8 unexpected pointer", cur_ptr_nxt, 0);
        else begin
          logic [31:0] p;
          p = ptr_q.pop_front();
          chk(cur_ptr_nxt == p, "R8 pointer", cur_ptr_nxt, p);
        end
      end
      if (st_txint_set != st_nsum_set) chk(1'b0, "R6 pulse pair", st_txint_set, st_nsum_set);
      if (st_txint_set) ti_cnt++;
      if (len_err) err_cnt++;
      if (mem_req && mem_ack && !mem_we && mem_addr == watch_addr) watch_cnt++;
      if (mem_req || fd_valid) quiet = 0; else quiet++;
    end
  end

  task automatic put_desc(input logic [31:0] a, input bit own, input bit ls, input bit eor,
                          input logic [15:0] s1, input logic [11:0] s2, input logic [31:0] bf);
    logic [31:0] w [4];
    w[0] = {own, 1'b0, ls, 7'b0, eor, 21'h0ABC5};
    w[1] = {4'h0, s2, s1};
    w[2] = bf;
    w[3] = 32'hDEAD_0000 | a;
    for (int k = 0; k < 4; k++) begin
      mem[a[12:2] + 11'(k)] = w[k];
      sh[a[12:2] + 11'(k)]  = w[k];
    end
  endtask

  task automatic set_ring(input logic [31:0] b);
    @(negedge clk);
    tx_base = b; ld_val = b; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
    m_cur = b;
  endtask

  task automatic model_walk();
    logic [31:0] c, w0, w1, bf, wa;
    int s1, s2, len;
    logic [7:0] bt;
    c = m_cur;
    for (int n = 0; n < 64; n++) begin
      w0 = sh[c[12:2]];
      if (!w0[31]) break;
      w1 = sh[c[12:2] + 11'd1];
      bf = sh[c[12:2] + 11'd2];
      s1 = int'(w1[11:0]); s2 = int'(w1[27:16]); len = s1 + s2;
      if (s1 > 2048 || s2 != 0) exp_err++;
      for (int j = 0; j < len; j++) begin
        wa = bf + 32'((j / 4) * 4);
        bt = sh[wa[12:2]][8*(j%4) +: 8];
        byte_q.push_back({m_first && (j == 0), w0[29] && (j == len - 1), bt});
      end
      if (len > 0) m_first = 1'b0;
      sh[c[12:2]] = w0 & ~32'h8000_0000;
      if (w0[29]) begin exp_ti++; m_first = 1'b1; end
      c = w0[21] ? tx_base : c + 32'd32;
      ptr_q.push_back(c);
    end
    m_cur = c;
  endtask

  task automatic poll_once();
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
  endtask

  // start expectations, poll, wait for quiet, then compare totals
  task automatic run_pass(input string name, input int extra_polls);
    int ti0, er0, t;
    exp_ti = 0; exp_err = 0;
    model_walk();
    ti0 = ti_cnt; er0 = err_cnt;
    poll_once();
    for (int k = 0; k < extra_polls; k++) begin
      repeat (4) @(negedge clk);
      poll_once();
    end
    t = 0;
    while ((quiet < 40 || byte_q.size() != 0 || ptr_q.size() != 0) && t < 60000) begin
      @(negedge clk); t++;
    end
    chk(byte_q.size() == 0, {"R3 bytes left ", name}, byte_q.size(), 0);
    chk(ptr_q.size() == 0, {"R8 pointer updates left ", name}, ptr_q.size(), 0);
    chk(cur_ptr == m_cur, {"R8 final pointer ", name}, cur_ptr, m_cur);
    chk(ti_cnt - ti0 == exp_ti, {"R6 done pulses ", name}, ti_cnt - ti0, exp_ti);
    chk(err_cnt - er0 == exp_err, {"R9 error pulses ", name}, err_cnt - er0, exp_err);
    for (int k = 0; k < 16; k++)
      chk(mem[k*8] == sh[k*8], {"R7 write-back ", name}, mem[k*8], sh[k*8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R2 watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int w0c;
    cur_ptr = '0;
    for (int i = 0; i < MW; i++) begin
      mem[i] = (i * 32'h9E37_79B1) ^ 32'h1234_5678;
      sh[i]  = mem[i];
    end
    for (int i = 0; i < 64; i++) begin
      mem[i] = '0; sh[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!mem_req && !fd_valid && !cur_ptr_we && !st_txint_set && !len_err, "R1 reset outputs",
        {mem_req, fd_valid, cur_ptr_we, st_txint_set, len_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !fd_valid && !cur_ptr_we && !st_txint_set && !st_nsum_set && !len_err,
        "R1 after reset", {mem_req, fd_valid, cur_ptr_we, st_txint_set, st_nsum_set, len_err}, 0);

    // T1: single frame, size1 upper nibble ignored, stop on non-owned
    set_ring(32'h0);
    put_desc(32'h000, 1, 1, 0, 16'h300A, 12'h0, 32'h400);
    put_desc(32'h020, 0, 0, 0, 16'h0004, 12'h0, 32'h400);
    watch_addr = 32'h20; w0c = watch_cnt;
    run_pass("single", 0);
    chk(watch_cnt - w0c == 1, "R2 stop reads", watch_cnt - w0c, 1);

    // T2: frame across three descriptors, middle one empty, under stalls
    stall_en = 1'b1; rdy_rand = 1'b1;
    put_desc(32'h020, 1, 0, 0, 16'd5, 12'h0, 32'h500);
    put_desc(32'h040, 1, 0, 0, 16'd0, 12'h0, 32'h600);
    put_desc(32'h060, 1, 1, 0, 16'd7, 12'h0, 32'h604);
    put_desc(32'h080, 0, 0, 0, 16'd1, 12'h0, 32'h600);
    run_pass("multi", 0);

    // T3: zero-length last segment still signals completion
    put_desc(32'h080, 1, 1, 0, 16'd0, 12'h0, 32'h600);
    run_pass("zero", 0);

    // T4: end-of-ring wraps to base, then stops on the cleared first entry
    set_ring(32'h100);
    put_desc(32'h100, 1, 1, 0, 16'd4, 12'h0, 32'h700);
    put_desc(32'h120, 1, 1, 1, 16'd6, 12'h0, 32'h710);
    run_pass("wrap", 0);

    // T5: length limits: 2048 fine, size2 nonzero and 2049 flagged
    put_desc(32'h100, 1, 1, 0, 16'd2048, 12'h0, 32'h400);
    put_desc(32'h120, 1, 1, 0, 16'd3, 12'd2, 32'hC00);
    put_desc(32'h140, 1, 1, 1, 16'd2049, 12'h0, 32'h1000);
    run_pass("lengths", 0);

    // T6: polls during a pass give exactly one more pass
    set_ring(32'h180);
    put_desc(32'h180, 1, 1, 0, 16'd40, 12'h0, 32'h800);
    put_desc(32'h1A0, 0, 1, 0, 16'd4, 12'h0, 32'h800);
    watch_addr = 32'h1A0; w0c = watch_cnt;
    run_pass("repoll", 2);
    chk(watch_cnt - w0c == 2, "R10 extra pass reads", watch_cnt - w0c, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule